// File: doc/BRIEF.md
# General-Purpose I/O Port with Standby Handling

This block is an eight-pin bidirectional I/O port that a processor reaches over a simple synchronous register bus: a 16-bit address, a write strobe with write data, and a read strobe whose data returns one clock later. For each pin it produces an output level and an output enable, and it samples the pin's input level. The pad tristate drivers are outside the block, which only produces their enables.

Three registers sit on the bus. A direction register chooses, pin by pin, whether the pin drives. It can only be written, and the value it takes on initialisation depends on the chip's operating mode. An output data register holds the level each driving pin puts out. A read-only pin-level register returns the synchronised state of the pins. Hardware standby puts the direction register back to its initial value. Software standby leaves it alone. While software standby lasts, a hold control chooses whether the driving pins keep their level or all float.

Top module: `gpio_sbport`

## Requirements
- R1: A synchronous reset loads the direction register with 0x80 (only pin 7 drives) when `op_mode` is 4, 5 or 6, and with 0x00 when `op_mode` is 7. A direction bit of 1 makes that pin's `pin_oe` bit high.
- R2: While `hw_stby` is high, the direction register is reloaded every cycle with the value R1 gives for the current `op_mode`. The output data register keeps its contents.
- R3: Software standby does not change the direction register. When `sw_stby` falls, `pin_oe` again equals the direction value from before standby.
- R4: A write at address 0xFEBE loads the direction register from `bus_wdata`. From the next cycle, `pin_oe` bit n equals bit n of the written value.
- R5: A read at address 0xFEBE returns 0x00, whatever the direction register holds.
- R6: The output data register at address 0xFF6E resets to 0x00, can be written and read back, and drives `pin_out` bit for bit.
- R7: A read at address 0xFF5E returns the pin levels through a two-flop synchronizer and one sampling register, so a level reaches this register three clocks after it appears on `pin_in`. Writes to this address change no register.
- R8: While `sw_stby` is high and `stby_hold` is 0, every `pin_oe` bit is 0. While `sw_stby` is high and `stby_hold` is 1, `pin_oe` keeps following the direction register.
- R9: `bus_rdata` carries the addressed value in the cycle after the one in which `bus_rd` is sampled high. It is 0x00 after a cycle without a read, and 0x00 for a read of any address other than the three registers.
- R10: Writes to the direction register while `hw_stby` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_mode | input | 3 | Operating mode, 4 to 7; selects the direction initial value |
| hw_stby | input | 1 | Hardware standby, active high |
| sw_stby | input | 1 | Software standby, active high |
| stby_hold | input | 1 | 1: keep driving during software standby; 0: float all pins |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output levels |
| pin_oe | output | 8 | Pin output enables |

## Verification
The direction register cannot be read back over the bus, so its contents can only be seen through `pin_oe`. The hardest case is to show that each standby kind treats it correctly. The bench first writes a direction value that differs from both initial values. It then enters software standby, first with the hold control set and then with it cleared, and checks that the enables either stay at that value or float. It leaves standby and checks that the enables return unchanged. Last, it raises hardware standby under different modes, including a direction write during standby, and checks that the enables fall back to the mode's initial value while the data register and `pin_out` are untouched.

// File: rtl/gpio_sbport_pkg.sv
package gpio_sbport_pkg;

    // Register selected by a bus address
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_DAT  = 2'd2,
        SEL_PIN  = 2'd3
    } reg_sel_e;

    localparam logic [2:0] MODE_SINGLE_CHIP = 3'd7;

    // Initial direction value: top pin drives in modes 4..6, none in mode 7
    function automatic logic [7:0] dir_init_8(input logic [2:0] mode);
        return (mode == MODE_SINGLE_CHIP) ? 8'h00 : 8'h80;
    endfunction

endpackage

// File: rtl/gpio_sbport_sync.sv
module gpio_sbport_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) stage[0] <= d;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) stage[s] <= stage[s-1];
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_sbport_regs.sv
module gpio_sbport_regs
    import gpio_sbport_pkg::*;
#(
    parameter int          PINS     = 8,
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] DIR_ADDR = 16'hFEBE,
    parameter logic [15:0] DAT_ADDR = 16'hFF6E,
    parameter logic [15:0] PIN_ADDR = 16'hFF5E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_mode,
    input  logic              hw_stby,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PINS-1:0]   bus_wdata,
    input  logic              bus_rd,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_sync,
    output logic [PINS-1:0]   dir_q,
    output logic [PINS-1:0]   dat_q
);
    localparam logic [PINS-1:0] TOP_PIN = PINS'(1) << (PINS-1);

    reg_sel_e        sel;
    logic [PINS-1:0] pin_q;
    logic [PINS-1:0] dir_init;

    always_comb begin
        if (bus_addr == ADDR_W'(DIR_ADDR))      sel = SEL_DIR;
        else if (bus_addr == ADDR_W'(DAT_ADDR)) sel = SEL_DAT;
        else if (bus_addr == ADDR_W'(PIN_ADDR)) sel = SEL_PIN;
        else                                    sel = SEL_NONE;
    end

    assign dir_init = (op_mode == MODE_SINGLE_CHIP) ? '0 : TOP_PIN;

    // Direction: reset and hardware standby both reinitialise it
    always_ff @(posedge clk) begin
        if (rst || hw_stby)                    dir_q <= dir_init;
        else if (bus_wr && sel == SEL_DIR)     dir_q <= bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                               dat_q <= '0;
        else if (bus_wr && sel == SEL_DAT)     dat_q <= bus_wdata;
    end

    // Pin-level sampling register, fed from the synchronizer
    always_ff @(posedge clk) begin
        if (rst) pin_q <= '0;
        else     pin_q <= pin_sync;
    end

    always_ff @(posedge clk) begin
        if (rst || !bus_rd) begin
            bus_rdata <= '0;
        end else begin
            unique case (sel)
                SEL_DAT: bus_rdata <= dat_q;
                SEL_PIN: bus_rdata <= pin_q;
                default: bus_rdata <= '0;   // direction is write-only
            endcase
        end
    end
endmodule

// File: rtl/gpio_sbport_drive.sv
module gpio_sbport_drive #(
    parameter int PINS = 8
) (
    input  logic [PINS-1:0] dir_q,
    input  logic [PINS-1:0] dat_q,
    input  logic            sw_stby,
    input  logic            stby_hold,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe
);
    logic float_all;

    assign float_all = sw_stby && !stby_hold;

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        assign pin_oe[i]  = dir_q[i] && !float_all;
        assign pin_out[i] = dat_q[i];
    end
endmodule

// File: rtl/gpio_sbport.sv
module gpio_sbport #(
    parameter int          PINS        = 8,
    parameter int          ADDR_W      = 16,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] DIR_ADDR    = 16'hFEBE,
    parameter logic [15:0] DAT_ADDR    = 16'hFF6E,
    parameter logic [15:0] PIN_ADDR    = 16'hFF5E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_mode,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              stby_hold,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PINS-1:0]   bus_wdata,
    input  logic              bus_rd,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);
    logic [PINS-1:0] pin_sync;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] dat_q;

    gpio_sbport_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_sbport_regs #(
        .PINS(PINS), .ADDR_W(ADDR_W),
        .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR), .PIN_ADDR(PIN_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .op_mode   (op_mode),
        .hw_stby   (hw_stby),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pin_sync  (pin_sync),
        .dir_q     (dir_q),
        .dat_q     (dat_q)
    );

    gpio_sbport_drive #(.PINS(PINS)) u_drive (
        .dir_q     (dir_q),
        .dat_q     (dat_q),
        .sw_stby   (sw_stby),
        .stby_hold (stby_hold),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );
endmodule

// File: rtl/gpio_sbport_checker.sv
module gpio_sbport_checker
    import gpio_sbport_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [2:0]  op_mode,
    input logic        hw_stby,
    input logic        sw_stby,
    input logic        stby_hold,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_rdata,
    input logic [7:0]  pin_out,
    input logic [7:0]  pin_oe
);
    // R1: after a reset cycle the enables show the mode's initial direction
    a_r1_reset_dir: assert property (@(posedge clk)
        rst |=> (sw_stby || pin_oe == dir_init_8($past(op_mode))));

    // R2: hardware standby reinitialises the direction register
    a_r2_hw_reinit: assert property (@(posedge clk) disable iff (rst)
        hw_stby |=> (sw_stby || pin_oe == dir_init_8($past(op_mode))));

    // R3: holding software standby with no write keeps the enables steady
    a_r3_sw_keeps_dir: assert property (@(posedge clk) disable iff (rst)
        (sw_stby && stby_hold && !hw_stby && !bus_wr)
            |=> (!sw_stby || !stby_hold || $stable(pin_oe)));

    // R6: pin levels change only after a bus write
    a_r6_out_needs_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_wr)) |-> $stable(pin_out));

    // R8: floating software standby drives nothing
    a_r8_float: assert property (@(posedge clk) disable iff (rst)
        (sw_stby && !stby_hold) |-> pin_oe == 8'h00);

    // R9: no read strobe last cycle means zero read data
    a_r9_idle_rdata: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> bus_rdata == 8'h00);
endmodule

bind gpio_sbport gpio_sbport_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_mode   (op_mode),
    .hw_stby   (hw_stby),
    .sw_stby   (sw_stby),
    .stby_hold (stby_hold),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/test_gpio_sbport.sv
module test_gpio_sbport;
    localparam logic [15:0] A_DIR = 16'hFEBE;
    localparam logic [15:0] A_DAT = 16'hFF6E;
    localparam logic [15:0] A_PIN = 16'hFF5E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_mode = 3'd4;
    logic        hw_stby = 1'b0, sw_stby = 1'b0, stby_hold = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_sbport i_gpio_sbport (
        .clk(clk), .rst(rst), .op_mode(op_mode), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .stby_hold(stby_hold), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: pops an expected item one cycle after each read strobe
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected read data", bus_rdata, 8'hxx);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic do_reset(input logic [2:0] mode);
        @(negedge clk);
        op_mode = mode; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: pushes the expected value, then strobes a read
    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        do_reset(3'd4);
        check("R1 mode4 reset oe", pin_oe, 8'h80);
        check("R6 reset pin_out", pin_out, 8'h00);
        check("R9 idle rdata", bus_rdata, 8'h00);
        rd(A_DAT, 8'h00, "R6 reset data read");

        do_reset(3'd7);
        check("R1 mode7 reset oe", pin_oe, 8'h00);
        do_reset(3'd5);
        check("R1 mode5 reset oe", pin_oe, 8'h80);

        wr(A_DIR, 8'h5A);
        check("R4 dir write oe", pin_oe, 8'h5A);
        rd(A_DIR, 8'h00, "R5 dir read zero");

        wr(A_DAT, 8'hC3);
        check("R6 pin_out", pin_out, 8'hC3);
        rd(A_DAT, 8'hC3, "R6 data readback");

        pin_in = 8'h96;
        repeat (4) @(negedge clk);
        rd(A_PIN, 8'h96, "R7 pin level read");
        wr(A_PIN, 8'h11);
        rd(A_PIN, 8'h96, "R7 pin write ignored");
        rd(A_DAT, 8'hC3, "R7 pin write leaves data");
        check("R7 pin write leaves oe", pin_oe, 8'h5A);
        rd(16'h1234, 8'h00, "R9 unmapped read");

        // pin latency: new level not yet visible two clocks after change
        @(negedge clk); pin_in = 8'h3C;
        @(negedge clk);
        rd(A_PIN, 8'h96, "R7 sync latency");
        rd(A_PIN, 8'h3C, "R7 sync arrival");

        @(negedge clk); sw_stby = 1'b1; stby_hold = 1'b1;
        @(negedge clk);
        check("R8 hold keeps oe", pin_oe, 8'h5A);
        stby_hold = 1'b0;
        #1 check("R8 float oe", pin_oe, 8'h00);
        repeat (3) @(negedge clk);
        sw_stby = 1'b0; stby_hold = 1'b1;
        @(negedge clk);
        check("R3 dir kept after sw standby", pin_oe, 8'h5A);

        @(negedge clk); op_mode = 3'd6; hw_stby = 1'b1;
        @(negedge clk);
        check("R2 hw standby oe mode6", pin_oe, 8'h80);
        check("R2 hw standby keeps pin_out", pin_out, 8'hC3);
        wr(A_DIR, 8'hFF);
        check("R10 dir write ignored in hw standby", pin_oe, 8'h80);
        op_mode = 3'd7;
        @(negedge clk);
        check("R2 hw standby oe mode7", pin_oe, 8'h00);
        hw_stby = 1'b0;
        @(negedge clk);
        check("R2 oe after hw standby", pin_oe, 8'h00);
        rd(A_DAT, 8'hC3, "R2 data kept after hw standby");

        repeat (3) @(negedge clk);
        check("R9 queue drained", 8'(exp_q.size()), 8'h00);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule